// File: doc/BRIEF.md
# Synch Field Deviation Checker

This block watches the received line while a synch field window is open and decides whether the synch byte was sent at a rate too far from the receiver's current baud divider. It counts system clock cycles between falling edges of the line. Two tests run side by side. The first compares the whole span, from the first to the last of five falling edges, with eight times the current divider. The second compares each gap between neighbouring falling edges with twice the current divider, and flags only gaps that end too early. A gap that runs long is left to the whole-span test.

An upstream stage opens the window after a break. It holds the divider steady while the window is open. The single-cycle error pulse goes to the header error logic. Closing the window discards any partial measurement.

Top module: `lin_sync_dev_check`

## Requirements
- R1: While reset is asserted and after its release, with no window open, `devError` is 0.
- R2: A falling edge is a cycle where `rxLine` is sampled 0 after being sampled 1 in the cycle before, while `windowActive` is 1. Let T be the number of clock cycles from the first to the fifth such edge and D the divider. When the fifth edge arrives with no earlier error, `devError` pulses exactly when |T - 8D| x 256 > 37 x 8D.
- R3: Let I be the cycle count between consecutive falling edges, for the second to the fifth edge. When (2D - I) x 64 > 11 x 2D, `devError` pulses at that edge and the remaining edges are not evaluated.
- R4: A gap longer than 2D never raises an error by itself. Only the whole-span rule of R2 can flag slow timing.
- R5: At most one pulse per window. After a pulse, or after the fifth edge, further falling edges cause no pulse until the window closes and reopens.
- R6: While `windowActive` is 0, falling edges are ignored. Closing the window discards a partial measurement, so the next window starts again from its first edge.
- R7: Both rules use the value on `divider` at the time of the edges, so the same line timing passes or fails depending on that value.
- R8: The pulse appears in the clock cycle right after the edge that decided it, and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Receive line, already synchronised to clk |
| windowActive | input | 1 | High while the synch field is expected |
| divider | input | DIV_W | Current baud divider in clock cycles per bit |
| devError | output | 1 | One-cycle deviation error pulse |

## Verification
The edge that decides an error is registered once on its way to `devError`. So the pulse is due one cycle after the clock edge that samples the falling line level. The bench drives the line on falling clock edges and samples the output on the next falling edge. It records the cycle index of every falling level it drives and expects the pulse exactly one index later (R8). Because it counts every pulse across the whole window and its tail, both early and stray pulses show up as errors.

// File: rtl/lin_sync_dev_pkg.sv
package lin_sync_dev_pkg;

  typedef struct packed {
    logic startAll;    // first edge: both counters restart
    logic restartGap;  // later edge: gap counter restarts
  } measStrobe_t;

  typedef enum logic [1:0] {
    WAIT_FIRST = 2'd0,
    MEASURING  = 2'd1,
    FINISHED   = 2'd2
  } phase_t;

endpackage

// File: rtl/lin_sync_dev_path.sv
module lin_sync_dev_path
  import lin_sync_dev_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned EDGES       = 5,
  parameter int unsigned WHOLE_NUM   = 37,
  parameter int unsigned WHOLE_SHIFT = 8,
  parameter int unsigned GAP_NUM     = 11,
  parameter int unsigned GAP_SHIFT   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  measStrobe_t      strobe,
  input  logic [DIV_W-1:0] divider,
  output logic             gapEarly,
  output logic             wholeOff
);

  localparam int unsigned CW = DIV_W + 4;
  localparam int unsigned PW = CW + 10;
  localparam logic [CW-1:0] CNT_MAX = '1;

  // index 0: gap since previous edge, index 1: span since first edge
  logic [CW-1:0] cntOut [2];

  for (genvar g = 0; g < 2; g++) begin : gen_cnt
    logic          clrG;
    logic [CW-1:0] cntR;

    if (g == 0) begin : gen_gap
      assign clrG = strobe.startAll | strobe.restartGap;
    end else begin : gen_whole
      assign clrG = strobe.startAll;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cntR <= '0;
      else if (clrG)             cntR <= CW'(1);
      else if (cntR != CNT_MAX)  cntR <= cntR + CW'(1);
    end

    assign cntOut[g] = cntR;

    // R2: a saturated count stays pinned until the next restart
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cntR == CNT_MAX && !clrG) |=> (cntR == CNT_MAX));
  end

  logic [PW-1:0] gapExp, wholeExp, gapNow, wholeNow, wholeDiff;

  always_comb begin
    gapExp    = PW'(divider) << 1;
    wholeExp  = gapExp * PW'(EDGES - 1);
    gapNow    = PW'(cntOut[0]);
    wholeNow  = PW'(cntOut[1]);
    wholeDiff = (wholeNow >= wholeExp) ? (wholeNow - wholeExp) : (wholeExp - wholeNow);
    gapEarly  = (gapNow < gapExp) &&
                (((gapExp - gapNow) << GAP_SHIFT) > (gapExp * PW'(GAP_NUM)));
    wholeOff  = (wholeDiff << WHOLE_SHIFT) > (wholeExp * PW'(WHOLE_NUM));
  end

endmodule

// File: rtl/lin_sync_dev_ctrl.sv
module lin_sync_dev_ctrl
  import lin_sync_dev_pkg::*;
#(
  parameter int unsigned EDGES = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxLine,
  input  logic        windowActive,
  input  logic        gapEarly,
  input  logic        wholeOff,
  output measStrobe_t strobe,
  output logic        devError
);

  localparam int unsigned EW = $clog2(EDGES + 1);

  phase_t        phase, nextPhase;
  logic [EW-1:0] edgeNum, nextEdge;
  logic          prevRx, fallNow, errNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevRx <= 1'b1;
    else        prevRx <= rxLine;
  end

  assign fallNow = windowActive && prevRx && !rxLine;

  always_comb begin
    nextPhase = phase;
    nextEdge  = edgeNum;
    errNext   = 1'b0;
    strobe    = '0;
    if (!windowActive) begin
      nextPhase = WAIT_FIRST;
      nextEdge  = '0;
    end else begin
      case (phase)
        WAIT_FIRST: if (fallNow) begin
          nextPhase       = MEASURING;
          nextEdge        = EW'(1);
          strobe.startAll = 1'b1;
        end
        MEASURING: if (fallNow) begin
          strobe.restartGap = 1'b1;
          nextEdge          = edgeNum + EW'(1);
          if (gapEarly) begin
            errNext   = 1'b1;
            nextPhase = FINISHED;
          end else if (edgeNum == EW'(EDGES - 1)) begin
            errNext   = wholeOff;
            nextPhase = FINISHED;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= WAIT_FIRST;
      edgeNum  <= '0;
      devError <= 1'b0;
    end else begin
      phase    <= nextPhase;
      edgeNum  <= nextEdge;
      devError <= errNext;
    end
  end

  // R5: never two pulses back to back
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    devError |=> !devError);

  // R6: a closed window produces no pulse in the following cycle
  assert_quiet_when_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !windowActive |=> !devError);

  // R8: a pulse only follows a qualified falling edge
  assert_pulse_after_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fallNow |=> !devError);

  // R5: edge count stays within one window's worth
  assert_edge_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edgeNum <= EW'(EDGES));

endmodule

// File: rtl/lin_sync_dev_check.sv
module lin_sync_dev_check
  import lin_sync_dev_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned EDGES       = 5,
  parameter int unsigned WHOLE_NUM   = 37,
  parameter int unsigned WHOLE_SHIFT = 8,
  parameter int unsigned GAP_NUM     = 11,
  parameter int unsigned GAP_SHIFT   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxLine,
  input  logic             windowActive,
  input  logic [DIV_W-1:0] divider,
  output logic             devError
);

  measStrobe_t strobe;
  logic        gapEarly, wholeOff;

  lin_sync_dev_ctrl #(.EDGES(EDGES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .rxLine       (rxLine),
    .windowActive (windowActive),
    .gapEarly     (gapEarly),
    .wholeOff     (wholeOff),
    .strobe       (strobe),
    .devError     (devError)
  );

  lin_sync_dev_path #(
    .DIV_W(DIV_W), .EDGES(EDGES),
    .WHOLE_NUM(WHOLE_NUM), .WHOLE_SHIFT(WHOLE_SHIFT),
    .GAP_NUM(GAP_NUM), .GAP_SHIFT(GAP_SHIFT)
  ) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .divider  (divider),
    .gapEarly (gapEarly),
    .wholeOff (wholeOff)
  );

endmodule

// File: tb/sim_lin_sync_dev_check.sv
module sim_lin_sync_dev_check;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxLine = 1'b1;
  logic        windowActive = 1'b0;
  logic [15:0] divider = 16'd8;
  logic        devError;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int lastDrive = 0;
  int pulses = 0;
  int pulseAt = -1;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lin_sync_dev_check u0 (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine),
    .windowActive(windowActive), .divider(divider), .devError(devError)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sample the output, then drive the next input levels
  task automatic tick(input logic rv, input logic wv);
    @(negedge clk);
    if (devError) begin
      pulses++;
      pulseAt = cyc;
    end
    lastDrive = cyc;
    cyc++;
    rxLine = rv;
    windowActive = wv;
  endtask

  // edge number (2..5) that must raise the error, 0 for none
  function automatic int expectEdge(input int d, input int g[4]);
    int e, t, w, diff;
    e = 2 * d;
    t = 0;
    for (int k = 0; k < 4; k++) begin
      if (g[k] < e && (e - g[k]) * 64 > 11 * e) return k + 2;
      t += g[k];
    end
    w = 4 * e;
    diff = (t >= w) ? t - w : w - t;
    if (diff * 256 > 37 * w) return 5;
    return 0;
  endfunction

  task automatic runWindow(input int d, input int g[4], input string req);
    int falls[5];
    int expE, expAt;
    divider = 16'(d);
    pulses = 0;
    pulseAt = -1;
    repeat (3) tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    falls[0] = lastDrive;
    for (int k = 0; k < 4; k++) begin
      repeat (g[k] / 2 - 1) tick(1'b0, 1'b1);
      repeat (g[k] - g[k] / 2) tick(1'b1, 1'b1);
      tick(1'b0, 1'b1);
      falls[k + 1] = lastDrive;
    end
    // extra quick edges after the fifth must be ignored (R5)
    repeat (2) tick(1'b0, 1'b1);
    repeat (2) tick(1'b1, 1'b1);
    repeat (2) tick(1'b0, 1'b1);
    repeat (2) tick(1'b1, 1'b1);
    repeat (3) tick(1'b1, 1'b0);
    expE  = expectEdge(d, g);
    expAt = (expE != 0) ? falls[expE - 1] + 1 : -1;
    check(pulses == ((expE != 0) ? 1 : 0), {req, " R5 pulse count"}, pulses, (expE != 0) ? 1 : 0);
    check(pulseAt == expAt, {req, " R8 pulse cycle"}, pulseAt, expAt);
  endtask

  initial begin
    int g[4];
    int dl[3];
    dl[0] = 6; dl[1] = 8; dl[2] = 13;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(devError == 1'b0, "R1 in reset", int'(devError), 0);
    rst_n = 1'b1;
    repeat (4) tick(1'b1, 1'b0);
    check(devError == 1'b0, "R1 after reset", int'(devError), 0);
    check(pulses == 0, "R1 idle pulses", pulses, 0);

    foreach (dl[i]) begin
      int d, e;
      d = dl[i];
      e = 2 * d;
      // R2: uniform gaps around nominal, whole-span rule
      for (int k = -6; k <= 6; k++) begin
        for (int j = 0; j < 4; j++) g[j] = e + k;
        runWindow(d, g, "R2");
      end
      // R3: one short gap at each position, swept shortfall
      for (int p = 0; p < 4; p++) begin
        for (int s = 0; s <= d; s++) begin
          for (int j = 0; j < 4; j++) g[j] = e;
          g[p] = e - s;
          runWindow(d, g, "R3");
        end
      end
      // R4: one long gap, never flagged on its own
      for (int p = 0; p < 4; p++) begin
        for (int j = 0; j < 4; j++) g[j] = e;
        g[p] = e + d;
        runWindow(d, g, "R4 late gap");
        g[p] = e + 2 * d;
        runWindow(d, g, "R4 slow span");
      end
    end

    // R5: every gap very short, only the first one reports
    for (int j = 0; j < 4; j++) g[j] = 8;
    runWindow(8, g, "R5 repeated early");

    // R6: edges with the window closed are ignored
    pulses = 0;
    divider = 16'd8;
    repeat (6) begin
      tick(1'b0, 1'b0);
      tick(1'b1, 1'b0);
    end
    tick(1'b1, 1'b0);
    check(pulses == 0, "R6 closed window", pulses, 0);

    // R6: partial window discarded, next window starts fresh
    pulses = 0;
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    repeat (7) tick(1'b0, 1'b1);
    repeat (8) tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    repeat (3) tick(1'b1, 1'b0);
    check(pulses == 0, "R6 partial window", pulses, 0);
    for (int j = 0; j < 4; j++) g[j] = 16;
    runWindow(8, g, "R6 fresh window");

    // R7: identical timing judged against two divider values
    runWindow(8, g, "R7 matching divider");
    runWindow(10, g, "R7 larger divider");
    runWindow(7, g, "R7 smaller divider");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule